// File: doc/BRIEF.md
# Code Overlay Address Remapper

This block sits between a processor's instruction fetch port and the external memory controller. Each 17-bit code-space byte address is turned into a physical target. The target is one of three things: the internal ROM, the external code-memory chip select with the address passed through, or the data-RAM chip select with a 22-bit address. The 128 KB code space is cut into eight 16 KB sections, and each section can be redirected on its own into fast RAM. Redirected sections are stacked at the very top of the installed RAM: section 7 takes the topmost 16 KB and section 0 sits lowest.

Fetch requests come in on a valid/ready stream and leave on a valid/ready stream with a one-entry register in between. A request is accepted on a clock edge where `fetch_valid` and `fetch_ready` are both high. `fetch_ready` is high whenever the output register is empty or is being drained in that same cycle. The output holds its address and selects unchanged while `phys_valid` is high and `phys_ready` is low. The target is resolved at acceptance, so writing a configuration register never changes a request that is already held.

A second, purely combinational window lets the data side look at code space through the same mapping. Addresses in the ROM region are refused on this window.

Top module: `code_overlay_remap`

## Requirements
- R1: After reset the section enables are all 0, the size code is 0 and `phys_valid` is low.
- R2: A fetch to a section whose enable bit is 0, outside the ROM region, raises only `phys_code_cs` and outputs the fetch address zero-extended to 22 bits.
- R3: A fetch to a section whose enable bit is 1, outside the ROM region, raises only `phys_data_cs` and outputs RAM_BYTES − 128 KB + fetch address. Section k therefore lands at RAM_BYTES − (8 − k)·16 KB, and the 14-bit offset within the section is kept.
- R4: The size code selects RAM_BYTES: 0 → 128 KB, 1 → 256 KB, 2 → 1 MB, 3 → 4 MB.
- R5: The section of an address is bits [16:14]. Enable bit k affects only section k.
- R6: Addresses below ROM_BYTES (default 4096) go to the internal ROM. In that case `phys_rom` is high, both chip selects are low and the address passes through, whatever the enables say.
- R7: While `phys_valid` is high, exactly one of `phys_code_cs`, `phys_data_cs` and `phys_rom` is high.
- R8: While `phys_valid` is high and `phys_ready` is low, the output fields stay stable and `fetch_ready` is low. `fetch_ready` equals NOT `phys_valid` OR `phys_ready`.
- R9: An enable or size write takes effect only for fetches accepted on a later edge. A request that is already held keeps its target.
- R10: The data window maps `win_addr` combinationally with the same rules as R2–R5. Addresses in the ROM region raise `win_blocked` with both window chip selects low.
- R11: A configuration write with `cfg_sel` = 0 loads all 8 enable bits from `cfg_wdata[7:0]`. With `cfg_sel` = 1 it loads the size code from `cfg_wdata[1:0]`, and bits [7:2] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = section enables, 1 = RAM size code |
| cfg_wdata | input | 8 | Configuration write data |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request accepted this cycle |
| fetch_addr | input | 17 | Code-space byte address |
| phys_valid | output | 1 | Physical request valid |
| phys_ready | input | 1 | Memory controller takes the request |
| phys_addr | output | 22 | Physical byte address |
| phys_code_cs | output | 1 | Target is external code memory |
| phys_data_cs | output | 1 | Target is data RAM (overlay) |
| phys_rom | output | 1 | Target is internal ROM |
| win_addr | input | 17 | Data-side window code address |
| win_phys_addr | output | 22 | Window physical address |
| win_code_cs | output | 1 | Window target is code memory |
| win_data_cs | output | 1 | Window target is data RAM |
| win_blocked | output | 1 | Window address is in the ROM region |

## Verification
The hardest case to reach from the ports is a configuration write that lands while a mapped request is stalled in the output register, with a second fetch already waiting behind it. The stimulus holds `phys_ready` low after one fetch is accepted. It then flips the enable of that fetch's section and presents a second fetch into the same section. The bench checks that the held request keeps its code-memory target through the stall. After `phys_ready` is released, it checks that the next request picks up the overlay.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CODE_AW_D  = 17;
  localparam int PHYS_AW_D  = 22;
  localparam int SECT_W_D   = 3;
  localparam int ROM_BYTES_D = 4096;

  typedef enum logic {
    CFG_ENABLE = 1'b0,
    CFG_SIZE   = 1'b1
  } cfg_sel_e;

  typedef enum logic [1:0] {
    SZ_128K = 2'd0,
    SZ_256K = 2'd1,
    SZ_1M   = 2'd2,
    SZ_4M   = 2'd3
  } ram_size_e;
endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
  import ovl_pkg::*;
#(
  parameter int NSECT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [NSECT-1:0] wdata,
  output logic [NSECT-1:0] sect_en,
  output logic [1:0]       size_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_en   <= '0;
      size_code <= SZ_128K;
    end else if (we) begin
      if (cfg_sel_e'(sel) == CFG_ENABLE) sect_en <= wdata;
      else                               size_code <= wdata[1:0];
    end
  end
endmodule

// File: rtl/ovl_map.sv
module ovl_map #(
  parameter int CODE_AW   = 17,
  parameter int PHYS_AW   = 22,
  parameter int SECT_W    = 3,
  parameter int ROM_BYTES = 4096,
  localparam int NSECT    = 1 << SECT_W
) (
  input  logic [CODE_AW-1:0] addr,
  input  logic [NSECT-1:0]   sect_en,
  input  logic [1:0]         size_code,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic               code_cs,
  output logic               data_cs,
  output logic               rom_hit
);
  localparam logic [CODE_AW:0]  ROM_LIM   = (CODE_AW+1)'(ROM_BYTES);
  localparam logic [PHYS_AW:0]  CODE_SPAN = (PHYS_AW+1)'(1) << CODE_AW;

  logic [PHYS_AW:0]   ram_bytes;
  logic [PHYS_AW:0]   ovl_base_w;
  logic [SECT_W-1:0]  sect;
  logic               in_rom;
  logic               ovl;

  always_comb begin
    unique case (size_code)
      2'd0:    ram_bytes = CODE_SPAN;
      2'd1:    ram_bytes = CODE_SPAN << 1;
      2'd2:    ram_bytes = CODE_SPAN << 3;
      default: ram_bytes = (PHYS_AW+1)'(1) << PHYS_AW;
    endcase
  end

  assign ovl_base_w = ram_bytes - CODE_SPAN;
  assign sect       = addr[CODE_AW-1 -: SECT_W];
  assign in_rom     = {1'b0, addr} < ROM_LIM;
  assign ovl        = !in_rom && sect_en[sect];

  always_comb begin
    rom_hit = in_rom;
    code_cs = !in_rom && !ovl;
    data_cs = ovl;
    if (ovl) phys_addr = ovl_base_w[PHYS_AW-1:0] + PHYS_AW'(addr);
    else     phys_addr = PHYS_AW'(addr);
  end
endmodule

// File: rtl/ovl_fetch_stage.sv
module ovl_fetch_stage #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/code_overlay_remap.sv
module code_overlay_remap
  import ovl_pkg::*;
#(
  parameter int CODE_AW   = CODE_AW_D,
  parameter int PHYS_AW   = PHYS_AW_D,
  parameter int SECT_W    = SECT_W_D,
  parameter int ROM_BYTES = ROM_BYTES_D,
  localparam int NSECT    = 1 << SECT_W,
  localparam int PAY_W    = PHYS_AW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [NSECT-1:0]   cfg_wdata,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [CODE_AW-1:0] fetch_addr,
  output logic               phys_valid,
  input  logic               phys_ready,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic               phys_code_cs,
  output logic               phys_data_cs,
  output logic               phys_rom,
  input  logic [CODE_AW-1:0] win_addr,
  output logic [PHYS_AW-1:0] win_phys_addr,
  output logic               win_code_cs,
  output logic               win_data_cs,
  output logic               win_blocked
);
  logic [NSECT-1:0]   sect_en;
  logic [1:0]         size_code;
  logic [PHYS_AW-1:0] f_addr;
  logic               f_code, f_data, f_rom;
  logic [PAY_W-1:0]   pay_in, pay_out;

  ovl_cfg_regs #(.NSECT(NSECT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .sect_en(sect_en), .size_code(size_code)
  );

  ovl_map #(.CODE_AW(CODE_AW), .PHYS_AW(PHYS_AW), .SECT_W(SECT_W), .ROM_BYTES(ROM_BYTES))
  u_fetch_map (
    .addr(fetch_addr), .sect_en(sect_en), .size_code(size_code),
    .phys_addr(f_addr), .code_cs(f_code), .data_cs(f_data), .rom_hit(f_rom)
  );

  ovl_map #(.CODE_AW(CODE_AW), .PHYS_AW(PHYS_AW), .SECT_W(SECT_W), .ROM_BYTES(ROM_BYTES))
  u_win_map (
    .addr(win_addr), .sect_en(sect_en), .size_code(size_code),
    .phys_addr(win_phys_addr), .code_cs(win_code_cs), .data_cs(win_data_cs),
    .rom_hit(win_blocked)
  );

  assign pay_in = {f_addr, f_code, f_data, f_rom};

  ovl_fetch_stage #(.W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(fetch_valid), .in_ready(fetch_ready), .in_data(pay_in),
    .out_valid(phys_valid), .out_ready(phys_ready), .out_data(pay_out)
  );

  assign {phys_addr, phys_code_cs, phys_data_cs, phys_rom} = pay_out;

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_valid |-> ($countones({phys_code_cs, phys_data_cs, phys_rom}) == 1));

  // R2
  code_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && f_code) |=> (phys_addr == PHYS_AW'($past(fetch_addr))));

  // R3
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_data_cs |-> (win_phys_addr[CODE_AW-SECT_W-1:0] == win_addr[CODE_AW-SECT_W-1:0]));

  // R10
  win_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_blocked |-> (!win_code_cs && !win_data_cs));

  // R6
  rom_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_valid && phys_rom) |-> (!phys_code_cs && !phys_data_cs));
endmodule

// File: tb/sim_code_overlay_remap.sv
module sim_code_overlay_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        fetch_valid = 1'b0, fetch_ready;
  logic [16:0] fetch_addr = '0;
  logic        phys_valid, phys_ready = 1'b1;
  logic [21:0] phys_addr;
  logic        phys_code_cs, phys_data_cs, phys_rom;
  logic [16:0] win_addr = '0;
  logic [21:0] win_phys_addr;
  logic        win_code_cs, win_data_cs, win_blocked;

  int checks = 0, errors = 0;
  logic [7:0] m_en = '0;
  logic [1:0] m_size = '0;

  always #2.5 clk = ~clk;

  code_overlay_remap u0 (.*);

  function automatic logic [22:0] ram_of(input logic [1:0] s);
    case (s)
      2'd0: return 23'h020000;
      2'd1: return 23'h040000;
      2'd2: return 23'h100000;
      default: return 23'h400000;
    endcase
  endfunction

  // expected {addr, code, data, rom}
  function automatic logic [24:0] expect_of(input logic [16:0] a);
    logic [22:0] base;
    base = ram_of(m_size) - 23'h020000;
    if (a < 17'd4096) return {5'd0, a, 3'b001};
    if (m_en[a[16:14]]) return {base[21:0] + {5'd0, a}, 3'b010};
    return {5'd0, a, 3'b100};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_size = d[1:0]; else m_en = d;
  endtask

  task automatic do_fetch(input string req, input logic [16:0] a);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(req, {7'd0, phys_valid, phys_addr, phys_code_cs, phys_data_cs, phys_rom},
          {7'd0, 1'b1, expect_of(a)});
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, phys_valid}, 32'd0);
    win_addr = 17'h1C010; #1;
    check("R1 enables", {31'd0, win_code_cs}, 32'd1);
  endtask

  task automatic t_passthru;
    do_fetch("R2 code", 17'h12345);
    do_fetch("R2 code top", 17'h1FFFE);
  endtask

  task automatic t_overlay;
    cfg_write(1'b0, 8'h80);
    cfg_write(1'b1, 8'h01);
    do_fetch("R3 sect7 256K", 17'h1C010);
    check("R3 sect7 addr", {10'd0, phys_addr}, 32'h03C010);
    cfg_write(1'b1, 8'h03);
    do_fetch("R4 4M", 17'h1C010);
    check("R4 4M addr", {10'd0, phys_addr}, 32'h3FC010);
    cfg_write(1'b1, 8'hFE);
    do_fetch("R11 size bits ignored", 17'h1FFFF);
    check("R11 1M addr", {10'd0, phys_addr}, 32'h0FFFFF);
    cfg_write(1'b1, 8'h00);
    do_fetch("R4 128K", 17'h1C000);
    check("R4 128K addr", {10'd0, phys_addr}, 32'h01C000);
  endtask

  task automatic t_sections;
    cfg_write(1'b1, 8'h01);
    cfg_write(1'b0, 8'h24);
    do_fetch("R5 sect2", 17'h08004);
    do_fetch("R5 sect3 off", 17'h0C004);
    do_fetch("R5 sect5", 17'h14100);
    do_fetch("R5 sect1 off", 17'h04000);
  endtask

  task automatic t_rom;
    cfg_write(1'b0, 8'hFF);
    do_fetch("R6 rom", 17'h00800);
    check("R6 rom flag", {31'd0, phys_rom}, 32'd1);
    do_fetch("R6 edge above rom", 17'h01000);
  endtask

  task automatic t_backpressure;
    cfg_write(1'b1, 8'h01);
    cfg_write(1'b0, 8'h00);
    @(negedge clk);
    phys_ready = 1'b0;
    fetch_valid = 1'b1; fetch_addr = 17'h1C000;
    @(negedge clk);
    fetch_addr = 17'h1C004;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h80;
    check("R8 ready low", {31'd0, fetch_ready}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; m_en = 8'h80;
    check("R9 held target", {7'd0, phys_valid, phys_addr, phys_code_cs, phys_data_cs, phys_rom},
          {7'd1, 22'h01C000, 3'b100});
    @(negedge clk);
    check("R8 stable", {10'd0, phys_addr}, 32'h01C000);
    phys_ready = 1'b1; #1;
    check("R8 ready follows", {31'd0, fetch_ready}, 32'd1);
    @(negedge clk);
    fetch_valid = 1'b0;
    check("R9 next fetch", {7'd0, phys_valid, phys_addr, phys_code_cs, phys_data_cs, phys_rom},
          {7'd1, 22'h03C004, 3'b010});
    @(negedge clk);
    check("R8 drained", {31'd0, phys_valid}, 32'd0);
  endtask

  task automatic t_window;
    cfg_write(1'b1, 8'h02);
    cfg_write(1'b0, 8'h01);
    win_addr = 17'h02345; #1;
    check("R10 overlay", {7'd0, win_phys_addr, win_code_cs, win_data_cs, win_blocked},
          {7'd0, 22'h0E2345, 3'b010});
    win_addr = 17'h0FFF0; #1;
    check("R10 code", {7'd0, win_phys_addr, win_code_cs, win_data_cs, win_blocked},
          {7'd0, 22'h00FFF0, 3'b100});
    win_addr = 17'h00010; #1;
    check("R10 blocked", {29'd0, win_code_cs, win_data_cs, win_blocked}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_overlay();
    t_sections();
    t_rom();
    t_backpressure();
    t_window();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule